// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block computes the column address presented on each beat of a synchronous DRAM read or write burst. A one-cycle start strobe captures a start column, a burst length code and a burst order. From the next cycle on, the block produces one column per cycle while the advance enable is high. Fixed bursts of 2, 4 or 8 beats stay inside the naturally aligned block of columns that holds the start column. A full-page burst walks the whole 512-column page and only ends on a stop or a new start.

The output side works like a stream. `beat_valid_o` marks a valid column. `adv_en_i` acts as the ready: a beat is used, and the generator moves on, only on a clock edge where both are high. When `adv_en_i` is low, the column, the valid flag and the last flag hold their values. This is how a controller applies clock suspend. The start and stop strobes are plain control inputs and act whatever the level of `adv_en_i`.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid_o` and `last_o` are low, and `last_o` is never high while `beat_valid_o` is low.
- R2: On the clock edge where `start_i` is high, the block captures `start_col_i`, `len_code_i` and `il_i`. In the next cycle `beat_valid_o` is high and `col_o` equals the captured start column.
- R3: With `il_i`=0 (sequential order), length codes 1, 2 and 3 give bursts of 2, 4 and 8 beats. Each beat adds one to the low log2(length) bits and wraps them within that field. The higher column bits keep the start column's value.
- R4: With `il_i`=1 (interleave order), the column on beat k is the start column with its low log2(length) bits XORed with k. For example, length 8 starting at column 2 gives 2,3,0,1,6,7,4,5.
- R5: Length code 0 gives a single-beat burst. Codes 4, 5 and 6 are reserved and also act as a single beat.
- R6: `last_o` is high on the final beat of a fixed-length burst. After that beat is advanced, `beat_valid_o` is low in the next cycle.
- R7: Length code 7 selects a full-page burst. The column adds one per advanced beat, modulo 512. `last_o` is never asserted, and the burst runs until a stop or a new start.
- R8: A full-page burst requested with `il_i`=1 runs in sequential order.
- R9: While a burst is running, a cycle with `adv_en_i` low and no strobe leaves `col_o`, `beat_valid_o` and `last_o` unchanged in the next cycle.
- R10: `stop_i` without `start_i` makes `beat_valid_o` low in the next cycle. When both strobes are high on the same edge, the start wins.
- R11: A start during a burst drops the remaining beats. It begins a new burst of the full newly captured length at the new column.
- R12: Changes on `start_col_i`, `len_code_i` and `il_i` while no start is present have no effect on a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the presented parameters |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | 0:1, 1:2, 2:4, 3:8, 7:full page, 4-6:single beat |
| il_i | input | 1 | Burst order: 0 sequential, 1 interleave |
| stop_i | input | 1 | End the current burst |
| adv_en_i | input | 1 | Advance enable (ready) for the current beat |
| col_o | output | 9 | Column of the current beat |
| beat_valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat ends a fixed-length burst |

## Verification
Every result comes from registers, so a start, stop or advance seen on one rising edge shows on the outputs for the whole following cycle: the first column one cycle after the start, the next column one cycle after an advanced beat, and valid low one cycle after a stop or a final advance. The bench drives inputs on the falling edge and runs its reference model on the rising edge with the same inputs the design samples. It compares the outputs on the next falling edge, so each check sits exactly one register stage after its cause. The sequences cover full-page wrap, interleave order, suspended cycles, simultaneous strobes and restarts.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int CODE_W       = 3;
  localparam int MAX_FIXED_LG = 3;

  localparam logic [CODE_W-1:0] LEN_ONE  = 3'd0;
  localparam logic [CODE_W-1:0] LEN_TWO  = 3'd1;
  localparam logic [CODE_W-1:0] LEN_FOUR = 3'd2;
  localparam logic [CODE_W-1:0] LEN_EIGHT= 3'd3;
  localparam logic [CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {ORDER_SEQ = 1'b0, ORDER_XOR = 1'b1} order_e;

  // log2 of a fixed burst length; reserved codes collapse to one beat
  function automatic int unsigned fixed_log(input logic [CODE_W-1:0] code);
    case (code)
      LEN_TWO:   return 1;
      LEN_FOUR:  return 2;
      LEN_EIGHT: return 3;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/colgen_mode.sv
module colgen_mode
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] len_code,
  input  logic              il_req,
  output logic              full_q,
  output order_e            order_q,
  output logic [COL_W-1:0]  mask_q,
  output logic [COL_W-1:0]  last_idx_q
);

  logic             full_d;
  order_e           order_d;
  logic [COL_W-1:0] mask_d;
  logic [COL_W-1:0] last_idx_d;
  int unsigned      lg;

  always_comb begin
    full_d  = (len_code == LEN_PAGE);
    // interleave is not defined across a whole page
    order_d = (il_req && !full_d) ? ORDER_XOR : ORDER_SEQ;
    lg      = fixed_log(len_code);
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_d[b] = full_d || (b < lg);
  end

  assign last_idx_d = full_d ? '0 : mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      order_q    <= ORDER_SEQ;
      mask_q     <= '0;
      last_idx_q <= '0;
    end else if (load) begin
      full_q     <= full_d;
      order_q    <= order_d;
      mask_q     <= mask_d;
      last_idx_q <= last_idx_d;
    end
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             adv_en,
  input  logic             full,
  input  logic [COL_W-1:0] last_idx,
  output logic             active_q,
  output logic [COL_W-1:0] beat_q,
  output logic             last_beat
);

  assign last_beat = active_q && !full && (beat_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (active_q && adv_en) begin
      if (last_beat) active_q <= 1'b0;
      else           beat_q   <= beat_q + 1'b1;
    end
  end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] col_in,
  input  order_e           order,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col_out
);

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= col_in;
  end

  // carries only move upward, so masked low bits of the sum wrap in-block
  assign seq_col = base_q + beat;
  assign xor_col = base_q ^ beat;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic moved;
    assign moved      = (order == ORDER_XOR) ? xor_col[b] : seq_col[b];
    assign col_out[b] = mask[b] ? moved : base_q[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              il_i,
  input  logic              stop_i,
  input  logic              adv_en_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              last_o
);

  logic             mode_full;
  order_e           mode_order;
  logic [COL_W-1:0] mode_mask;
  logic [COL_W-1:0] mode_last_idx;
  logic [COL_W-1:0] beat;

  colgen_mode #(.COL_W(COL_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_i),
    .len_code   (len_code_i),
    .il_req     (il_i),
    .full_q     (mode_full),
    .order_q    (mode_order),
    .mask_q     (mode_mask),
    .last_idx_q (mode_last_idx)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .stop      (stop_i),
    .adv_en    (adv_en_i),
    .full      (mode_full),
    .last_idx  (mode_last_idx),
    .active_q  (beat_valid_o),
    .beat_q    (beat),
    .last_beat (last_o)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_i),
    .col_in  (start_col_i),
    .order   (mode_order),
    .mask    (mode_mask),
    .beat    (beat),
    .col_out (col_o)
  );

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic             adv_en_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             last_o,
  input logic             full_q
);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_valid_o && (col_o == $past(start_col_i)));

  // R9
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !adv_en_i && !start_i && !stop_i
      |=> beat_valid_o && $stable(col_o) && $stable(last_o));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !beat_valid_o);

  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && adv_en_i && !start_i |=> !beat_valid_o);

  // R7
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && beat_valid_o |-> !last_o);

  // R1
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_colgen_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .start_col_i  (start_col_i),
  .stop_i       (stop_i),
  .adv_en_i     (adv_en_i),
  .col_o        (col_o),
  .beat_valid_o (beat_valid_o),
  .last_o       (last_o),
  .full_q       (mode_full)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       il_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       adv_en_i = 1'b1;
  logic [8:0] col_o;
  logic       beat_valid_o;
  logic       last_o;

  always #2.5 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .il_i(il_i), .stop_i(stop_i), .adv_en_i(adv_en_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .last_o(last_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_req = "R1";

  // reference model state
  bit m_act = 0;
  int m_beat = 0, m_start = 0, m_len = 1;
  bit m_full = 0, m_il = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act = 1; m_beat = 0; m_start = start_col_i; m_il = il_i;
      m_full = (len_code_i == 3'd7);
      case (len_code_i)
        3'd1: m_len = 2;
        3'd2: m_len = 4;
        3'd3: m_len = 8;
        default: m_len = 1;
      endcase
    end else if (stop_i) m_act = 0;
    else if (m_act && adv_en_i) begin
      if (!m_full && m_beat == m_len - 1) m_act = 0;
      else m_beat = (m_beat + 1) % 512;
    end
  end

  function automatic int exp_col();
    int base, off;
    if (m_full) return (m_start + m_beat) % 512;
    off  = m_start % m_len;
    base = m_start - off;
    if (m_il) return base + (off ^ m_beat);
    return base + (off + m_beat) % m_len;
  endfunction

  always @(negedge clk) begin
    bit e_last;
    e_last = m_act && !m_full && (m_beat == m_len - 1);
    checks++;
    if (beat_valid_o !== m_act || last_o !== e_last ||
        (m_act && (int'(col_o) != exp_col()))) begin
      fails++;
      $display("FAIL %s cycle %0d: act valid=%0b last=%0b col=%0d exp valid=%0b last=%0b col=%0d",
               cur_req, cyc, beat_valid_o, last_o, col_o, m_act, e_last, exp_col());
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act hung exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic go(input string req, input int col, input int code, input bit il);
    @(negedge clk);
    cur_req = req;
    start_i = 1; start_col_i = 9'(col); len_code_i = 3'(code); il_i = il;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R3 sequential fixed lengths
    go("R3", 9'h1A3, 3, 0); idle(10);
    go("R3", 9'h00E, 2, 0); idle(5);
    go("R3", 9'h015, 1, 0); idle(3);
    // R4 interleave
    go("R4", 2, 3, 1); idle(10);
    go("R4", 9'h107, 2, 1); idle(5);
    // R5 single beat and reserved codes
    go("R5", 9'h0AA, 0, 0); idle(2);
    go("R5", 9'h033, 5, 1); idle(2);
    go("R5", 9'h034, 4, 0); idle(2);
    // R6 last and end of burst, back to back
    go("R6", 9'h040, 1, 0);
    go("R6", 9'h051, 1, 1); idle(3);
    // R7 full page wrap, then stop
    go("R7", 9'h1FD, 7, 0); idle(520);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0; idle(2);
    // R8 full page with interleave request
    go("R8", 9'h00F, 7, 1); idle(12);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0; idle(2);
    // R9 suspend pattern
    go("R9", 9'h0C5, 3, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); adv_en_i = (i % 3) != 1;
    end
    adv_en_i = 1; idle(4);
    // R9 start while suspended still loads
    @(negedge clk); adv_en_i = 0;
    go("R9", 9'h0C0, 2, 0); idle(3);
    adv_en_i = 1; idle(6);
    // R10 stop mid burst, then start and stop together
    go("R10", 9'h120, 3, 0); idle(2);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0; idle(2);
    @(negedge clk); stop_i = 1;
    go("R10", 9'h131, 2, 0);
    stop_i = 0; idle(6);
    // R11 restart mid burst with a new mode
    go("R11", 9'h062, 3, 0); idle(3);
    go("R11", 9'h19A, 2, 1); idle(1);
    go("R11", 9'h1FF, 7, 0); idle(4);
    go("R11", 9'h006, 3, 1); idle(10);
    // R12 mode inputs ignored without a start
    go("R12", 9'h0F3, 3, 0);
    start_col_i = 9'h011; len_code_i = 3'd7; il_i = 1;
    idle(10);
    cur_req = "R1";
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule